// File: doc/BRIEF.md
# Per-Core Compare Timer

This block is a timer that sits beside one processor core and watches a shared, free-running system count. The system count arrives as a 64-bit input. The block keeps a 64-bit offset and subtracts it from that count, which gives the core a private virtual count. It also keeps a 64-bit compare target. The timer fires once the virtual count has reached or passed the target.

Software can program the target in two ways. It can write the absolute 64-bit value. It can also write a 32-bit signed delta, which the block adds to the virtual count at the moment of the write. Reading the relative view returns the distance from now to the target, cut to 32 bits.

A small control register holds an enable bit and a mask bit. It also shows a status bit that reports the raw condition. The single interrupt output is a level signal. It is high only while the timer is enabled, unmasked and the condition holds. It is re-evaluated combinationally whenever the target, the offset, the control or the count changes.

Top module: `core_cmp_timer`

## Requirements
- R1: After reset the control, compare and offset registers read as zero and `irq_o` is low, whatever the system count is.
- R2: The condition holds when the virtual count is greater than or equal to the compare value, compared as unsigned 64-bit numbers. Equality counts as a hit.
- R3: `irq_o` is high exactly when control bit 0 (enable) is 1, control bit 1 (mask) is 0, and the condition holds.
- R4: Control read bit 2 (status) shows the condition while enable is 1, whatever the mask holds. It reads 0 while enable is 0.
- R5: A control write takes effect on the clock edge that captures it. If the condition already holds, `irq_o` rises right after that edge, with no further count change.
- R6: The virtual count is the system count minus the offset, modulo 2^64. It can be read at select 4.
- R7: Reading select 2 returns the compare value minus the virtual count, truncated to 32 bits and zero-extended on `rd_data_o`.
- R8: Writing select 2 sets the compare value to the virtual count plus `wr_data_i[31:0]` sign-extended to 64 bits. Bits 63:32 of the written data are ignored.
- R9: `irq_o` falls right after the edge of any compare or offset write that makes the condition false. It also falls as soon as the system count no longer meets the target.
- R10: Control bits 63:3 read as zero, and the status bit cannot be written. Writes to select 4 or to selects 5 to 7 change no register. Selects 5 to 7 read as zero.
- R11: Select encoding: 0 control, 1 compare, 2 relative value, 3 offset, 4 virtual count (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_count_i | input | 64 | Shared system count |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 3 | Register select for the read (combinational) |
| rd_data_o | output | 64 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted compare or offset register shows at the ports in two places. The relative-value read and the virtual-count read go wrong at once, and the interrupt level goes wrong on the first count where the bad value flips the comparison. A control register stuck in the wrong state shows on the status read and on `irq_o` right after the write edge, because both follow combinationally from it. Boundary vectors are therefore chosen where a one-count or sign error flips the level: equality, wrap of the offset subtraction, a target at the top of the unsigned range, and negative relative writes.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_CMP  = 3'd1,
      SEL_REL  = 3'd2,
      SEL_OFFS = 3'd3,
      SEL_VCNT = 3'd4
   } tmr_sel_e;

   localparam int unsigned CTL_EN_BIT   = 0;
   localparam int unsigned CTL_MASK_BIT = 1;
   localparam int unsigned CTL_STAT_BIT = 2;
endpackage

// File: rtl/tmr_count_view.sv
module tmr_count_view #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned REL_W = 32
) (
   input  logic [CNT_W-1:0] sys_cnt_i,
   input  logic [CNT_W-1:0] offset_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] vcnt_o,
   output logic             hit_o,
   output logic [REL_W-1:0] rel_o
);
   always_comb begin
      vcnt_o = sys_cnt_i - offset_i;
      hit_o  = (vcnt_o >= cmp_i);
      rel_o  = cmp_i[REL_W-1:0] - vcnt_o[REL_W-1:0];
   end

   // R2
   always_comb begin
      eq_hit_chk: assert ((cmp_i != vcnt_o) || hit_o);
   end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned REL_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [CNT_W-1:0] vcnt_i,
   output logic             en_o,
   output logic             mask_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic [CNT_W-1:0] offset_o
);
   localparam int unsigned EXT_W = CNT_W - REL_W;

   logic [CNT_W-1:0] rel_ext;
   tmr_sel_e         sel;

   always_comb begin
      sel     = tmr_sel_e'(wr_sel_i);
      rel_ext = {{EXT_W{wr_data_i[REL_W-1]}}, wr_data_i[REL_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o     <= 1'b0;
         mask_o   <= 1'b0;
         cmp_o    <= '0;
         offset_o <= '0;
      end else if (wr_en_i) begin
         case (sel)
            SEL_CTRL: begin
               en_o   <= wr_data_i[CTL_EN_BIT];
               mask_o <= wr_data_i[CTL_MASK_BIT];
            end
            SEL_CMP:  cmp_o    <= wr_data_i;
            SEL_REL:  cmp_o    <= vcnt_i + rel_ext;
            SEL_OFFS: offset_o <= wr_data_i;
            default:  ;
         endcase
      end
   end

   // R8
   rel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == 3'd2) |=>
         cmp_o == $past(vcnt_i) + {{EXT_W{$past(wr_data_i[REL_W-1])}}, $past(wr_data_i[REL_W-1:0])});

   // R10
   ignored_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i >= 3'd4) |=>
         ($stable(cmp_o) && $stable(offset_o) && $stable(en_o) && $stable(mask_o)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> ($stable(cmp_o) && $stable(offset_o) && $stable(en_o)));
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic mask_i,
   input  logic hit_i,
   output logic status_o,
   output logic irq_o
);
   logic fire;

   always_comb begin
      status_o = en_i & hit_i;
      fire     = status_o & ~mask_i;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= fire;
         end
         assign irq_o = irq_q;

         // R3
         reg_irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> $past(en_i && !mask_i));
      end else begin : g_comb
         assign irq_o = fire;

         // R3
         always_comb begin
            irq_gate_chk: assert (!irq_o || (en_i && !mask_i));
         end
         // R4
         always_comb begin
            irq_status_chk: assert (!irq_o || status_o);
         end
      end
   endgenerate
endmodule

// File: rtl/core_cmp_timer.sv
module core_cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W   = 64,
   parameter int unsigned REL_W   = 32,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] sys_count_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [2:0]       rd_sel_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic             irq_o
);
   generate
      if (REL_W < 2 || REL_W >= CNT_W) begin : g_bad_width
         $error("core_cmp_timer: REL_W must be at least 2 and below CNT_W");
      end
   endgenerate

   logic             en, mask, hit, status;
   logic [CNT_W-1:0] cmp, offs, vcnt;
   logic [REL_W-1:0] rel;

   tmr_count_view #(.CNT_W(CNT_W), .REL_W(REL_W)) view_i (
      .sys_cnt_i (sys_count_i),
      .offset_i  (offs),
      .cmp_i     (cmp),
      .vcnt_o    (vcnt),
      .hit_o     (hit),
      .rel_o     (rel)
   );

   tmr_regfile #(.CNT_W(CNT_W), .REL_W(REL_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .vcnt_i    (vcnt),
      .en_o      (en),
      .mask_o    (mask),
      .cmp_o     (cmp),
      .offset_o  (offs)
   );

   tmr_irq_out #(.REG_OUT(REG_OUT)) irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en),
      .mask_i   (mask),
      .hit_i    (hit),
      .status_o (status),
      .irq_o    (irq_o)
   );

   always_comb begin
      rd_data_o = '0;
      case (tmr_sel_e'(rd_sel_i))
         SEL_CTRL: begin
            rd_data_o[CTL_EN_BIT]   = en;
            rd_data_o[CTL_MASK_BIT] = mask;
            rd_data_o[CTL_STAT_BIT] = status;
         end
         SEL_CMP:  rd_data_o = cmp;
         SEL_REL:  rd_data_o[REL_W-1:0] = rel;
         SEL_OFFS: rd_data_o = offs;
         SEL_VCNT: rd_data_o = vcnt;
         default:  rd_data_o = '0;
      endcase
   end

   // R4
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (!irq_o || REG_OUT) && !status);
endmodule

// File: tb/core_cmp_timer_tb.sv
module core_cmp_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] sys = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [63:0] rd_data;
   logic        irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   core_cmp_timer dut_i (
      .clk(clk), .rst_n(rst_n), .sys_count_i(sys),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
   );

   typedef struct packed {
      logic [63:0] sys;
      logic [63:0] cmp;
      logic [63:0] offs;
      logic [1:0]  ctl;
      logic        irq;
      logic        stat;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{64'd100, 64'd100, 64'd0,  2'b01, 1'b1, 1'b1},
      '{64'd99,  64'd100, 64'd0,  2'b01, 1'b0, 1'b0},
      '{64'd100, 64'd100, 64'd0,  2'b11, 1'b0, 1'b1},
      '{64'd500, 64'd100, 64'd0,  2'b00, 1'b0, 1'b0},
      '{64'd150, 64'd100, 64'd60, 2'b01, 1'b0, 1'b0},
      '{64'd160, 64'd100, 64'd60, 2'b01, 1'b1, 1'b1},
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b01, 1'b1, 1'b1},
      '{64'd5,   64'h8000_0000_0000_0000, 64'd0, 2'b01, 1'b0, 1'b0},
      '{64'd5,   64'd0,   64'd10, 2'b01, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [63:0] d);
      rd_sel = s;
      #1 d = rd_data;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] v;
      sys = 64'd1234;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 64'd0);
      rd(3'd1, v); chk("R1 cmp", v, 64'd0);
      rd(3'd3, v); chk("R1 offs", v, 64'd0);
      chk("R1 irq", {63'd0, irq}, 64'd0);

      // table walk: R2 R3 R4 R6
      for (int i = 0; i < NV; i++) begin
         wr(3'd0, 64'd0);
         wr(3'd3, VECS[i].offs);
         wr(3'd1, VECS[i].cmp);
         sys = VECS[i].sys;
         wr(3'd0, {62'd0, VECS[i].ctl});
         #1;
         chk("R3 irq level", {63'd0, irq}, {63'd0, VECS[i].irq});
         rd(3'd0, v);
         chk("R4 ctrl read", v, {61'd0, VECS[i].stat, VECS[i].ctl});
         rd(3'd4, v);
         chk("R6 vcnt", v, VECS[i].sys - VECS[i].offs);
      end

      // R5 control write raises irq at the capturing edge
      wr(3'd0, 64'd0);
      wr(3'd3, 64'd0);
      wr(3'd1, 64'd150);
      sys = 64'd200;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 64'd1;
      chk("R5 before edge", {63'd0, irq}, 64'd0);
      @(posedge clk); #1;
      chk("R5 after edge", {63'd0, irq}, 64'd1);
      @(negedge clk); wr_en = 1'b0;

      // R9 deassert on compare and offset changes, and on count
      wr(3'd1, 64'd300);
      chk("R9 cmp raised", {63'd0, irq}, 64'd0);
      wr(3'd1, 64'd100);
      chk("R9 cmp lowered", {63'd0, irq}, 64'd1);
      wr(3'd3, 64'd150);
      chk("R9 offset raised", {63'd0, irq}, 64'd0);
      sys = 64'd260; #1;
      chk("R9 count catches up", {63'd0, irq}, 64'd1);
      sys = 64'd249; #1;
      chk("R9 count falls back", {63'd0, irq}, 64'd0);

      // R7 relative read
      wr(3'd3, 64'd0);
      sys = 64'd1000;
      wr(3'd1, 64'd1025);
      rd(3'd2, v); chk("R7 rel positive", v, 64'd25);
      wr(3'd1, 64'd990);
      rd(3'd2, v); chk("R7 rel negative", v, 64'h0000_0000_FFFF_FFF6);

      // R8 relative write, sign extension, upper data ignored
      wr(3'd3, 64'd100);
      wr(3'd2, 64'hABCD_1234_FFFF_FFF0);
      rd(3'd1, v); chk("R8 rel write neg", v, 64'd884);
      wr(3'd2, 64'hFFFF_0000_0000_0010);
      rd(3'd1, v); chk("R8 rel write pos", v, 64'd916);

      // R10 ctrl upper bits and status not writable, dead selects, R11 read zero
      wr(3'd1, 64'd5000);
      wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFD);
      rd(3'd0, v); chk("R10 ctrl write ones", v, 64'd1);
      wr(3'd4, 64'd7);
      wr(3'd5, 64'd9);
      wr(3'd7, 64'd3);
      rd(3'd1, v); chk("R10 cmp kept", v, 64'd5000);
      rd(3'd3, v); chk("R10 offs kept", v, 64'd100);
      rd(3'd0, v); chk("R10 ctrl kept", v, 64'd1);
      rd(3'd4, v); chk("R10 vcnt kept", v, 64'd900);
      rd(3'd6, v); chk("R11 dead select reads zero", v, 64'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule